// File: doc/BRIEF.md
# Per-Pixel Threshold Trim Sequencer

This block runs the threshold trim procedure for a group of pixel discriminators that share one reference ramp. While calibration mode is held, a shared 3-bit step counter starts at zero and moves up one level on each calibration strobe, through eight levels that divide a small fixed reference span (2 mV end to end) from its low end to its high end. Each pixel watches its own discriminator. At the first transition it sees in a run, it stores the step that was applied at that moment in its own trim register.

When calibration mode is released, the stored code of each pixel becomes a static tap-select code for the resistive ladder point that sets that pixel's reference. The ladder and the discriminators are outside the block. Each is seen only as a per-pixel tap-select field going out and a per-pixel flip bit coming in. A pixel that never flips by the end of the eighth level is given the top code and marked out of range. A done flag reports that the whole ramp has been applied and sampled.

Top module: `pixel_trim_seq`

## Requirements
- R1: After reset, every tap-select field is 0, every out-of-range flag is 0 and `cal_done` is 0.
- R2: A cycle with `cal_mode` high that follows a cycle with it low starts a run. From the next cycle the step is 0, `cal_done` is 0 and all out-of-range flags are clear. Flips in that starting cycle are not captured.
- R3: During a run, each cycle with `cal_strobe` high moves the step up by one, and the step saturates at 7. While calibration is active, every pixel's tap-select field shows the shared step. Pixel i uses bits [3i+2:3i] of `tap_sel`.
- R4: In a run cycle where pixel i has `flip[i]` high and has not yet captured, pixel i stores the step applied in that cycle.
- R5: After a pixel has captured in a run, further flips from it leave its stored code unchanged until the next run starts.
- R6: A strobe applied while the step is 7 ends the run, and `cal_done` is high from the next cycle. Each pixel that has not captured and is not flipping in that cycle stores 7 and raises its out-of-range flag. A pixel that flips in that cycle stores 7 with its flag low.
- R7: Once `cal_done` is high, strobes and flips change nothing. `cal_done` stays high, also in normal mode, until the next run starts.
- R8: In normal mode (`cal_mode` low), each tap-select field shows that pixel's stored code, and flips and strobes have no effect.
- R9: Leaving calibration before the run ends keeps the codes captured so far. Pixels that did not capture keep their earlier code, and `cal_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mode | input | 1 | High selects calibration, low selects normal use |
| cal_strobe | input | 1 | One-cycle pulse that advances the ramp step |
| flip | input | NPIX | Per-pixel discriminator output |
| tap_sel | output | 3*NPIX | Per-pixel ladder tap select, 3 bits per pixel |
| out_of_range | output | NPIX | Per-pixel flag: no flip seen over the whole ramp |
| cal_done | output | 1 | The eighth level has been applied and sampled |

## Verification
A wrong step counter shows up at once on every tap-select field during calibration, one cycle after the strobe that went wrong. A wrong capture flag or stored code stays hidden while calibration runs. It appears only when the bench drops `cal_mode`, because then the tap fields show the stored codes. For that reason, each run is followed by normal-mode cycles and compared there. The reference model is compared on every clock, so a stray done or out-of-range flag is caught in the cycle after the edge that set it.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int TRIM_W    = 3;
    localparam int STEP_LAST = (1 << TRIM_W) - 1;

    typedef logic [TRIM_W-1:0] trim_t;

    typedef struct packed {
        logic  active;
        trim_t step;
        logic  done;
    } seq_st_t;

    typedef struct packed {
        trim_t code;
        logic  got;
        logic  oor;
    } pix_st_t;
endpackage

// File: rtl/trim_step_ctr.sv
module trim_step_ctr
    import trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cal_mode,
    input  logic  cal_strobe,
    output logic  active,
    output trim_t step,
    output logic  done,
    output logic  entry,
    output logic  run,
    output logic  finish
);
    seq_st_t st_d, st_q;
    logic    at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.step == trim_t'(STEP_LAST));
        entry   = cal_mode & ~st_q.active;
        run     = cal_mode & st_q.active & ~st_q.done;
        finish  = run & cal_strobe & at_last;

        st_d.active = cal_mode;
        if (entry) begin
            st_d.step = '0;
            st_d.done = 1'b0;
        end else if (run && cal_strobe) begin
            if (at_last) begin
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign step   = st_q.step;
    assign done   = st_q.done;
endmodule

// File: rtl/trim_pixel_cell.sv
module trim_pixel_cell
    import trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  entry,
    input  logic  run,
    input  logic  finish,
    input  logic  active,
    input  trim_t step,
    input  logic  flip,
    output trim_t tap,
    output logic  oor
);
    pix_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (entry) begin
            st_d.got = 1'b0;
            st_d.oor = 1'b0;
        end else if (run && !st_q.got) begin
            if (flip) begin
                st_d.code = step;
                st_d.got  = 1'b1;
            end else if (finish) begin
                st_d.code = trim_t'(STEP_LAST);
                st_d.got  = 1'b1;
                st_d.oor  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap = active ? step : st_q.code;
    assign oor = st_q.oor;
endmodule

// File: rtl/pixel_trim_seq.sv
module pixel_trim_seq
    import trim_pkg::*;
#(
    parameter int NPIX = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cal_mode,
    input  logic                     cal_strobe,
    input  logic [NPIX-1:0]          flip,
    output logic [NPIX*TRIM_W-1:0]   tap_sel,
    output logic [NPIX-1:0]          out_of_range,
    output logic                     cal_done
);
    localparam int TAP_W = NPIX * TRIM_W;

    logic  seq_active, seq_entry, seq_run, seq_finish;
    trim_t seq_step;
    logic [TAP_W-1:0] tap_w;

    trim_step_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_mode   (cal_mode),
        .cal_strobe (cal_strobe),
        .active     (seq_active),
        .step       (seq_step),
        .done       (cal_done),
        .entry      (seq_entry),
        .run        (seq_run),
        .finish     (seq_finish)
    );

    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        trim_pixel_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .entry  (seq_entry),
            .run    (seq_run),
            .finish (seq_finish),
            .active (seq_active),
            .step   (seq_step),
            .flip   (flip[i]),
            .tap    (tap_w[i*TRIM_W +: TRIM_W]),
            .oor    (out_of_range[i])
        );
    end

    assign tap_sel = tap_w;
endmodule

// File: rtl/trim_seq_checker.sv
module trim_seq_checker
    import trim_pkg::*;
#(
    parameter int NPIX = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cal_mode,
    input logic                   cal_strobe,
    input logic [NPIX*TRIM_W-1:0] tap_sel,
    input logic [NPIX-1:0]        oor,
    input logic                   cal_done,
    input logic                   active,
    input trim_t                  step,
    input logic                   entry,
    input logic                   run
);
    p_entry_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (step == '0 && !cal_done && oor == '0));

    p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cal_strobe && step != trim_t'(STEP_LAST)) |=> step == trim_t'($past(step) + 1'b1));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cal_mode && step == trim_t'(STEP_LAST)) |=> step == trim_t'(STEP_LAST));

    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(run && cal_strobe && step == trim_t'(STEP_LAST)));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !entry) |=> cal_done);

    p_normal_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cal_mode) |=> ($stable(tap_sel) && $stable(oor)));

    for (genvar i = 0; i < NPIX; i++) begin : g_chk
        p_oor_code7_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!active && oor[i]) |-> tap_sel[i*TRIM_W +: TRIM_W] == trim_t'(STEP_LAST));
    end
endmodule

bind pixel_trim_seq trim_seq_checker #(.NPIX(NPIX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_mode   (cal_mode),
    .cal_strobe (cal_strobe),
    .tap_sel    (tap_sel),
    .oor        (out_of_range),
    .cal_done   (cal_done),
    .active     (seq_active),
    .step       (seq_step),
    .entry      (seq_entry),
    .run        (seq_run)
);

// File: tb/sim_pixel_trim_seq.sv
`timescale 1ns/1ps
module sim_pixel_trim_seq;
    localparam int NPIX = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cal_mode = 1'b0;
    logic              cal_strobe = 1'b0;
    logic [NPIX-1:0]   flip = '0;
    logic [NPIX*3-1:0] tap_sel;
    logic [NPIX-1:0]   out_of_range;
    logic              cal_done;

    always #10 clk = ~clk;

    pixel_trim_seq #(.NPIX(NPIX)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .cal_strobe(cal_strobe),
        .flip(flip), .tap_sel(tap_sel), .out_of_range(out_of_range), .cal_done(cal_done)
    );

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_active = 0, m_step = 0, m_done = 0;
    int m_code[NPIX];
    int m_got[NPIX];
    int m_oor[NPIX];
    int thr[NPIX];
    bit m_entry, m_run, m_fin;

    initial for (int i = 0; i < NPIX; i++) begin m_code[i] = 0; m_got[i] = 0; m_oor[i] = 0; end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_step = 0; m_done = 0;
            for (int i = 0; i < NPIX; i++) begin m_code[i] = 0; m_got[i] = 0; m_oor[i] = 0; end
        end else begin
            m_entry = cal_mode && (m_active == 0);
            m_run   = cal_mode && (m_active != 0) && (m_done == 0);
            m_fin   = m_run && cal_strobe && (m_step == 7);
            if (m_entry) begin
                m_step = 0; m_done = 0;
                for (int i = 0; i < NPIX; i++) begin m_got[i] = 0; m_oor[i] = 0; end
            end else if (m_run) begin
                for (int i = 0; i < NPIX; i++) begin
                    if (m_got[i] == 0 && flip[i]) begin
                        m_code[i] = m_step; m_got[i] = 1;
                    end else if (m_fin && m_got[i] == 0) begin
                        m_code[i] = 7; m_got[i] = 1; m_oor[i] = 1;
                    end
                end
                if (cal_strobe) begin
                    if (m_step < 7) m_step = m_step + 1;
                    else m_done = 1;
                end
            end
            m_active = cal_mode ? 1 : 0;
        end
    end

    task automatic check(input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        for (int i = 0; i < NPIX; i++) begin
            check($sformatf("tap px%0d", i), int'(tap_sel[i*3 +: 3]),
                  (m_active != 0) ? m_step : m_code[i]);
            check($sformatf("oor px%0d", i), int'(out_of_range[i]), m_oor[i]);
        end
        check("cal_done", int'(cal_done), m_done);
    endtask

    function automatic logic [NPIX-1:0] level_flips();
        logic [NPIX-1:0] f;
        for (int i = 0; i < NPIX; i++) f[i] = (m_step >= thr[i]);
        return f;
    endfunction

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (2) tick();

        // R2 R3 R4 R5 R6: ramp with level comparators; pixel 6 never flips,
        // pixel 7 flips only in the final strobe cycle
        thr = '{0, 1, 2, 3, 4, 5, 99, 99};
        cur_req = "R2 R3 R4 R5 R6";
        cal_mode = 1'b1;
        for (int c = 0; c < 30; c++) begin
            tick();
            cal_strobe = (c % 3 == 2);
            flip = level_flips();
            flip[7] = cal_strobe && (m_step == 7) && (m_active != 0);
        end
        // R7: done holds, inputs ignored
        cur_req = "R7";
        for (int c = 0; c < 8; c++) begin
            tick();
            cal_strobe = c[0];
            flip = NPIX'($urandom);
        end
        // R8: normal mode shows codes, inputs ignored
        cur_req = "R8 R6";
        cal_mode = 1'b0;
        for (int c = 0; c < 12; c++) begin
            tick();
            cal_strobe = $urandom_range(0, 1);
            flip = NPIX'($urandom);
        end

        // R5: noisy flips, then R9: abort mid-run
        cur_req = "R2 R5 R9";
        cal_mode = 1'b1; flip = '0; cal_strobe = 1'b0;
        for (int c = 0; c < 9; c++) begin
            tick();
            cal_strobe = (c % 2 == 1);
            flip = NPIX'($urandom) & NPIX'($urandom) & NPIX'($urandom);
        end
        tick();
        cal_mode = 1'b0; flip = '0; cal_strobe = 1'b0;
        for (int c = 0; c < 6; c++) begin
            tick();
            flip = NPIX'($urandom);
        end

        // R6: boundary, nobody flips -> all code 7 with flag
        cur_req = "R6 R3";
        cal_mode = 1'b1; flip = '0;
        for (int c = 0; c < 12; c++) begin
            tick();
            cal_strobe = 1'b1;
        end
        tick();
        cal_mode = 1'b0; cal_strobe = 1'b0;
        repeat (3) tick();

        // R4 R2: everyone flips at once from the start -> code 0, flags cleared
        cur_req = "R4 R2";
        cal_mode = 1'b1; flip = '1;
        for (int c = 0; c < 12; c++) begin
            tick();
            cal_strobe = (c % 2 == 0);
        end
        tick();
        cal_mode = 1'b0; cal_strobe = 1'b0; flip = '0;
        repeat (3) tick();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule